// File: doc/BRIEF.md
# Parallel ADC Readout Host Controller

This block sits on the host side of an eight-channel simultaneous-sampling successive-approximation converter that has a parallel data bus. When `start` is seen in idle, it latches the requested bus width and drives the two interface-select pins to match. It then pulses the convert-start line. It waits for the converter's busy line to rise and then to fall. After that it runs one burst of read strobes with chip-select held low, walking the channels from the first to the last. Each result is a 16-bit two's-complement word. It arrives either whole on the 16-bit bus, or as two byte reads on the low eight data lines, high byte first, which the block joins into one word.

When the burst ends, the block raises `valid` for one cycle and presents all channel results on a packed vector. During the burst it compares the converter's first-channel flag with its own channel position at every sample. It reports any mismatch on `align_err` together with `valid`. If busy does not fall within a bounded number of cycles, the block abandons the conversion. It then pulses `timeout_err` and returns to idle without touching the stored results.

The controller is one state machine with these states: S_IDLE, S_CONV, S_BUSY_RISE, S_BUSY_FALL, S_RD_LO, S_RD_HI, S_DONE and S_ABORT. The transitions are:
- S_IDLE to S_CONV on `start`.
- S_CONV to S_BUSY_RISE after CONV_W cycles.
- S_BUSY_RISE to S_BUSY_FALL when busy is high.
- S_BUSY_FALL to S_RD_LO when busy is low.
- Either busy state to S_ABORT on timeout.
- S_RD_LO to S_RD_HI after RD_LO_W cycles; the bus is sampled in the last of these cycles.
- S_RD_HI back to S_RD_LO after RD_HI_W cycles while reads remain.
- S_RD_HI to S_DONE after the final read.
- S_DONE and S_ABORT to S_IDLE after one cycle.

Top module: `adc_par_host`

## Requirements
- R1: After reset, `conv_start`=0, `cs_n`=1, `rd_n`=1, `valid`=0, `align_err`=0, `timeout_err`=0, both mode pins are 0 and `ch_data` is all zero.
- R2: When `start` is high in idle, `byte_mode` is latched. `par_ser_pin` and `byte_sel_pin` both equal the latched value, where 0 means a 16-bit word bus and 1 means a byte bus. `conv_start` is then high for exactly CONV_W cycles.
- R3: No read strobe is issued until busy has been seen high and has then returned low.
- R4: In word mode the burst has NUM_CH low pulses on `rd_n`. Each is RD_LO_W cycles low and is followed by RD_HI_W cycles high. `cs_n` is low throughout the burst and high once it ends.
- R5: In word mode the value on `adc_db` at the k-th read (k from 0) is stored as channel k in `ch_data[16k+15:16k]`.
- R6: In byte mode the burst has 2*NUM_CH reads. For each channel the first read supplies bits 15:8 and the second supplies bits 7:0, both taken from `adc_db[7:0]`. `adc_db[15:8]` is ignored.
- R7: `valid` is high for one cycle, RD_HI_W cycles after the final read strobe rises, and is low in the cycle after. `ch_data` holds the full result vector while `valid` is high.
- R8: `align_err` is high with `valid` if, at any sample in the burst, `first_ch` differed from (the current channel is channel 0). In byte mode the flag is expected high for both byte reads of channel 0. `align_err` is low otherwise.
- R9: If the two busy-wait states together last BUSY_LIMIT cycles, `timeout_err` pulses for one cycle. In that case no read strobe and no `valid` occur, `ch_data` is unchanged, and the block returns to idle.
- R10: `start` is ignored outside idle. A `start` pulse during a conversion produces no further convert pulse after that conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion and readout |
| byte_mode | input | 1 | Bus width for the request: 0 word, 1 byte |
| conv_start | output | 1 | Convert-start pulse to the converter |
| adc_busy | input | 1 | Converter busy line |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| par_ser_pin | output | 1 | Interface-select pin, high for byte bus |
| byte_sel_pin | output | 1 | Byte-select level driven onto the top data line, high for byte bus |
| adc_db | input | 16 | Converter data bus |
| first_ch | input | 1 | Converter flag marking channel 0 on the bus |
| valid | output | 1 | One-cycle pulse: result vector complete |
| ch_data | output | 128 | Packed results, channel 0 in the lowest 16 bits |
| align_err | output | 1 | Channel alignment mismatch, qualified by `valid` |
| timeout_err | output | 1 | One-cycle pulse: busy wait abandoned |

## Verification
The bench builds the block with CONV_W=2, RD_LO_W=3 and RD_HI_W=2. With those values the pulse widths can be counted cycle by cycle and differ from each other, so a swapped width is caught. BUSY_LIMIT is set to 64, which lets a stuck-busy conversion reach the abort within a short run while random busy lengths of up to 40 cycles still complete normally. The channel count and word width keep their defaults of eight and 16, so the byte-mode path walks sixteen reads and the index halving is exercised across every channel.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CONV,
        S_BUSY_RISE,
        S_BUSY_FALL,
        S_RD_LO,
        S_RD_HI,
        S_DONE,
        S_ABORT
    } host_state_e;

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_word_builder.sv
module adc_word_builder #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp,
    input  logic              byte_mode,
    input  logic              hi_phase,
    input  logic [DATA_W-1:0] bus,
    output logic              wr,
    output logic [DATA_W-1:0] word
);

    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (smp && byte_mode && hi_phase) begin
            hi_q <= bus[HALF_W-1:0];
        end
    end

    always_comb begin
        wr = smp && !(byte_mode && hi_phase);
        if (byte_mode) begin
            word = {hi_q, bus[HALF_W-1:0]};
        end else begin
            word = bus;
        end
    end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    parameter int CH_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [CH_W-1:0]          wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*DATA_W-1:0] bank_vec
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr && (wr_idx == CH_W'(g))) begin
                slot_q <= wr_data;
            end
        end
        assign bank_vec[g*DATA_W +: DATA_W] = slot_q;
    end

    // R9
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(bank_vec));

endmodule

// File: rtl/adc_par_host.sv
module adc_par_host
    import adc_host_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int DATA_W     = 16,
    parameter int CONV_W     = 2,
    parameter int RD_LO_W    = 3,
    parameter int RD_HI_W    = 2,
    parameter int BUSY_LIMIT = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     byte_mode,
    output logic                     conv_start,
    input  logic                     adc_busy,
    output logic                     cs_n,
    output logic                     rd_n,
    output logic                     par_ser_pin,
    output logic                     byte_sel_pin,
    input  logic [DATA_W-1:0]        adc_db,
    input  logic                     first_ch,
    output logic                     valid,
    output logic [NUM_CH*DATA_W-1:0] ch_data,
    output logic                     align_err,
    output logic                     timeout_err
);

    localparam int MAX_A  = (CONV_W > RD_LO_W) ? CONV_W : RD_LO_W;
    localparam int MAX_W  = (MAX_A > RD_HI_W) ? MAX_A : RD_HI_W;
    localparam int TMR_W  = $clog2(MAX_W + 1);
    localparam int BTO_W  = $clog2(BUSY_LIMIT + 1);
    localparam int RIDX_W = $clog2(2 * NUM_CH + 1);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam logic [RIDX_W-1:0] RD_WORD = RIDX_W'(NUM_CH);
    localparam logic [RIDX_W-1:0] RD_BYTE = RIDX_W'(2 * NUM_CH);

    host_state_e state_q, state_d;

    logic              byte_q;
    logic [RIDX_W-1:0] rd_idx;
    logic [BTO_W-1:0]  bto_cnt;
    logic              err_q;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_done;

    logic              smp;
    logic              hi_phase;
    logic [RIDX_W-1:0] ch_full;
    logic [CH_W-1:0]   ch_idx;
    logic              exp_first;
    logic              last_rd;
    logic              bto_hit;
    logic              accept;

    logic              wb_wr;
    logic [DATA_W-1:0] wb_word;

    assign accept    = (state_q == S_IDLE) && start;
    assign smp       = (state_q == S_RD_LO) && tmr_done;
    assign ch_full   = byte_q ? (rd_idx >> 1) : rd_idx;
    assign ch_idx    = ch_full[CH_W-1:0];
    assign exp_first = (ch_full == '0);
    assign hi_phase  = byte_q && !rd_idx[0];
    assign last_rd   = (rd_idx == (byte_q ? RD_BYTE : RD_WORD));
    assign bto_hit   = (bto_cnt == BTO_W'(BUSY_LIMIT - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_CONV;
            S_CONV:      if (tmr_done) state_d = S_BUSY_RISE;
            S_BUSY_RISE: begin
                if (adc_busy)     state_d = S_BUSY_FALL;
                else if (bto_hit) state_d = S_ABORT;
            end
            S_BUSY_FALL: begin
                if (!adc_busy)    state_d = S_RD_LO;
                else if (bto_hit) state_d = S_ABORT;
            end
            S_RD_LO:     if (tmr_done) state_d = S_RD_HI;
            S_RD_HI: begin
                if (tmr_done) state_d = last_rd ? S_DONE : S_RD_LO;
            end
            S_DONE:      state_d = S_IDLE;
            S_ABORT:     state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        conv_start  = 1'b0;
        cs_n        = 1'b1;
        rd_n        = 1'b1;
        valid       = 1'b0;
        align_err   = 1'b0;
        timeout_err = 1'b0;
        unique case (state_q)
            S_CONV:  conv_start = 1'b1;
            S_RD_LO: begin
                cs_n = 1'b0;
                rd_n = 1'b0;
            end
            S_RD_HI: cs_n = 1'b0;
            S_DONE: begin
                valid     = 1'b1;
                align_err = err_q;
            end
            S_ABORT: timeout_err = 1'b1;
            default: ;
        endcase
    end

    assign par_ser_pin  = byte_q;
    assign byte_sel_pin = byte_q;

    // phase timer loads on every state change
    assign tmr_load = (state_d != state_q);
    always_comb begin
        unique case (state_d)
            S_CONV:  tmr_val = TMR_W'(CONV_W - 1);
            S_RD_LO: tmr_val = TMR_W'(RD_LO_W - 1);
            S_RD_HI: tmr_val = TMR_W'(RD_HI_W - 1);
            default: tmr_val = '0;
        endcase
    end

    adc_phase_timer #(.CNT_W(TMR_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // burst bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q  <= 1'b0;
            rd_idx  <= '0;
            bto_cnt <= '0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                byte_q <= byte_mode;
                rd_idx <= '0;
                err_q  <= 1'b0;
            end else if (smp) begin
                rd_idx <= rd_idx + 1'b1;
                if (first_ch != exp_first) err_q <= 1'b1;
            end
            if ((state_q == S_BUSY_RISE) || (state_q == S_BUSY_FALL)) begin
                bto_cnt <= bto_cnt + 1'b1;
            end else begin
                bto_cnt <= '0;
            end
        end
    end

    adc_word_builder #(.DATA_W(DATA_W)) i_builder (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp       (smp),
        .byte_mode (byte_q),
        .hi_phase  (hi_phase),
        .bus       (adc_db),
        .wr        (wb_wr),
        .word      (wb_word)
    );

    adc_result_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wb_wr),
        .wr_idx   (ch_idx),
        .wr_data  (wb_word),
        .bank_vec (ch_data)
    );

    // R4
    rd_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);

    // R3
    no_read_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !adc_busy);

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R2
    mode_pins_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start || !cs_n) |=> $stable(par_ser_pin));

    // R9
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> (cs_n && !conv_start && !valid));

endmodule

// File: tb/test_adc_par_host.sv
module test_adc_par_host;

    localparam int NUM_CH = 8;
    localparam int DATA_W = 16;
    localparam int CONV_W = 2;
    localparam int RD_LO_W = 3;
    localparam int RD_HI_W = 2;
    localparam int BUSY_LIMIT = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic byte_mode = 1'b0;
    logic adc_busy = 1'b0;
    logic [DATA_W-1:0] adc_db = '0;
    logic first_ch = 1'b0;
    logic conv_start, cs_n, rd_n, par_ser_pin, byte_sel_pin;
    logic valid, align_err, timeout_err;
    logic [NUM_CH*DATA_W-1:0] ch_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [DATA_W-1:0] expv [NUM_CH];

    always #10 clk = ~clk;

    adc_par_host #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CONV_W(CONV_W),
        .RD_LO_W(RD_LO_W), .RD_HI_W(RD_HI_W), .BUSY_LIMIT(BUSY_LIMIT)
    ) i_adc_par_host (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode),
        .conv_start(conv_start), .adc_busy(adc_busy), .cs_n(cs_n), .rd_n(rd_n),
        .par_ser_pin(par_ser_pin), .byte_sel_pin(byte_sel_pin),
        .adc_db(adc_db), .first_ch(first_ch), .valid(valid), .ch_data(ch_data),
        .align_err(align_err), .timeout_err(timeout_err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] slot(input int c);
        return ch_data[c*DATA_W +: DATA_W];
    endfunction

    function automatic bit vec_match();
        for (int c = 0; c < NUM_CH; c++) if (slot(c) != expv[c]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic run_conv(input bit bm, input int busy_len, input int bad_ch,
                            input bit hang, input bit poke);
        int w, n, lw, hw, nrd, ch;
        bit rd_ok, cs_ok;
        logic [DATA_W-1:0] newv [NUM_CH];
        for (int c = 0; c < NUM_CH; c++) newv[c] = DATA_W'($urandom);
        @(negedge clk); byte_mode = bm; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(par_ser_pin == bm && byte_sel_pin == bm, "R2 mode pins", par_ser_pin, bm);
        w = 0;
        while (conv_start && w < 100) begin w++; @(negedge clk); end
        chk(w == CONV_W, "R2 conv width", w, CONV_W);
        adc_busy = 1'b1;
        if (hang) begin
            n = 0; rd_ok = 1'b1;
            while (!timeout_err && n < 1000) begin
                if (!rd_n || valid) rd_ok = 1'b0;
                n++; @(negedge clk);
            end
            chk(n == BUSY_LIMIT, "R9 timeout cycles", n, BUSY_LIMIT);
            chk(rd_ok && cs_n, "R9 no reads", rd_ok, 1);
            adc_busy = 1'b0;
            @(negedge clk);
            chk(!timeout_err && !valid, "R9 single pulse", timeout_err, 0);
            chk(vec_match(), "R9 data unchanged", slot(0), expv[0]);
            return;
        end
        rd_ok = 1'b1;
        for (int i = 0; i < busy_len; i++) begin
            start = (poke && i == busy_len / 2);
            @(negedge clk);
            if (!rd_n) rd_ok = 1'b0;
        end
        start = 1'b0;
        adc_busy = 1'b0;
        chk(rd_ok, "R3 no read during busy", rd_ok, 1);
        nrd = bm ? 2 * NUM_CH : NUM_CH;
        @(negedge rd_n); @(negedge clk);
        cs_ok = 1'b1;
        for (int r = 0; r < nrd; r++) begin
            ch = bm ? r / 2 : r;
            if (bm) adc_db = {8'($urandom), (r % 2 == 0) ? newv[ch][15:8] : newv[ch][7:0]};
            else adc_db = newv[ch];
            first_ch = (ch == 0) ^ (ch == bad_ch);
            lw = 0;
            while (!rd_n && lw < 100) begin
                if (cs_n) cs_ok = 1'b0;
                lw++; @(negedge clk);
            end
            if (r == 0) chk(lw == RD_LO_W, "R4 read low width", lw, RD_LO_W);
            hw = 0;
            while (rd_n && !valid && hw < 100) begin
                if (cs_n) cs_ok = 1'b0;
                hw++; @(negedge clk);
            end
            if (r == 0) chk(hw == RD_HI_W, "R4 read high width", hw, RD_HI_W);
            if (r == nrd - 1) chk(valid && hw == RD_HI_W, "R7 valid timing", hw, RD_HI_W);
            else chk(!valid, bm ? "R6 read count" : "R4 read count", r, nrd);
        end
        for (int c = 0; c < NUM_CH; c++) expv[c] = newv[c];
        chk(cs_ok, "R4 cs low in burst", cs_ok, 1);
        chk(cs_n && rd_n, "R4 cs released", cs_n, 1);
        chk(vec_match(), bm ? "R6 byte data" : "R5 word data", slot(NUM_CH - 1), expv[NUM_CH - 1]);
        chk(align_err == (bad_ch >= 0), "R8 align flag", align_err, bad_ch >= 0);
        @(negedge clk);
        chk(!valid && !align_err, "R7 valid one cycle", valid, 0);
        if (poke) begin
            rd_ok = 1'b1;
            repeat (6) begin if (conv_start) rd_ok = 1'b0; @(negedge clk); end
            chk(rd_ok, "R10 start ignored when busy", rd_ok, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int c = 0; c < NUM_CH; c++) expv[c] = '0;
        repeat (3) @(negedge clk);
        chk(!conv_start && cs_n && rd_n && !valid && !align_err && !timeout_err,
            "R1 reset outputs", {conv_start, cs_n, rd_n}, 3'b011);
        chk(!par_ser_pin && !byte_sel_pin, "R1 reset mode pins", par_ser_pin, 0);
        chk(ch_data == '0, "R1 reset data", slot(0), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_conv(1'b0, 10, -1, 1'b0, 1'b0);
        run_conv(1'b1, 20, -1, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++)
            run_conv(1'($urandom), 3 + int'($urandom % 38), -1, 1'b0, 1'b0);
        run_conv(1'b0, 8, 0, 1'b0, 1'b0);
        run_conv(1'b1, 8, 5, 1'b0, 1'b0);
        run_conv(1'b0, 8, -1, 1'b1, 1'b0);
        run_conv(1'b0, 12, -1, 1'b0, 1'b1);
        run_conv(1'b1, 5, -1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule